// File: doc/BRIEF.md
# Directory Home Node Controller

This block is the home node for a small range of cache lines in a coherence system where cores talk over point-to-point links rather than a shared bus. For each line it keeps a state (uncached, shared or modified), the core that owns a dirty copy, and a bit vector of the cores that hold clean copies. Cores send it read and read-exclusive requests, writebacks and acknowledgements. It answers with replies, and when other cores hold the line it sends recall, forward or invalidate messages to exactly those cores. No message is ever broadcast.

A static input picks how a read to a dirty line is served. In recall mode the home pulls the line back from the owner and then replies, which takes four hops. In forward mode the home hands the read to the owner, the owner serves the requester directly and acknowledges the home, which takes three hops. A single transaction engine handles one request at a time. While it waits for acknowledgements, any new request is refused with a retry message, so races on a line never reach the directory. Both message channels use valid/ready handshakes and carry a source, a destination, a type and a line address.

Message type codes on `in_type` and `out_type` (4 bits): read 0, read-exclusive 1, writeback 2, recall-ack 3, forward-ack 4, invalidate-ack 5, read-reply 8, exclusive-reply 9, recall 10, forwarded-read 11, invalidate 12, retry (NACK) 13. On every outgoing message, `out_src` is the core that started the transaction.

Top module: `dir_home`

## Requirements
- R1: After reset every line is uncached, `out_valid` is 0 and `in_ready` is 1.
- R2: A read (0) to a line that is uncached or shared gives a read-reply (8) to the requester, with src = dst = requester and the address echoed. The requester is then recorded as a sharer.
- R3: With `fwd_mode`=0, a read to a line modified at another core sends a recall (10) to the owner, with src = requester. Only after the owner's recall-ack (3) does the home send the read-reply (8). The line then becomes shared by both the former owner and the requester.
- R4: With `fwd_mode`=1, a read to a line modified at another core sends a forwarded-read (11) to the owner, with src = requester. The owner's forward-ack (4) ends the transaction with no reply from the home, and the line becomes shared by both cores.
- R5: A read-exclusive (1) to a shared line sends one invalidate (12) to each sharer other than the requester, in ascending core number. The exclusive-reply (9) is sent only after an invalidate-ack (5) has come back from every invalidated core. The requester then owns the line modified, with no sharers.
- R6: A read-exclusive to a line modified at another core sends a single invalidate to that owner before the exclusive-reply. A read-exclusive to an uncached line is answered with an exclusive-reply at once.
- R7: Recall, forward and invalidate messages go only to cores recorded as holding the line. Cores that hold no copy receive nothing.
- R8: While a transaction waits for acknowledgements, a read, read-exclusive or writeback to any line is answered with a retry (13) to its sender, with the address echoed. The directory is left unchanged.
- R9: A writeback (2) from the recorded owner returns the line to uncached. A writeback from any other core has no effect.
- R10: Once `out_valid` is asserted, it stays high and all outgoing fields stay unchanged until `out_ready` is seen high.
- R11: An acknowledgement of the wrong type, for another line, from a core that was not sent a message, or repeated, is consumed and ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fwd_mode | input | 1 | 1 = forward path for dirty reads, 0 = recall path |
| in_valid | input | 1 | Incoming message valid |
| in_ready | output | 1 | Home can take an incoming message |
| in_src | input | CORE_W | Sending core |
| in_type | input | 4 | Incoming message type code |
| in_addr | input | LINE_W | Line index |
| out_valid | output | 1 | Outgoing message valid |
| out_ready | input | 1 | Network accepts outgoing message |
| out_src | output | CORE_W | Core that started the transaction |
| out_dst | output | CORE_W | Destination core |
| out_type | output | 4 | Outgoing message type code |
| out_addr | output | LINE_W | Line index |

## Verification
The bench checks the ordering corners. It holds back the last invalidate-ack, and also feeds duplicate, wrong-type and wrong-line acks, so that a design counting raw ack messages would reply early and show up as an unexpected output. It sends new requests while acknowledgements are still pending; a design that did not block would disturb the directory, and this is caught later when the line is invalidated or reads through the wrong path. It also applies a writeback from a non-owner and a read-exclusive from a core that is itself a sharer. A design that cleared the owner on the wrong writeback, or invalidated the requester, would send messages that the exact-match scoreboard rejects. Throughout, a periodic `out_ready` stall exercises the hold rule on the outgoing channel.

// File: rtl/dir_pkg.sv
package dir_pkg;

  typedef enum logic [3:0] {
    MSG_RD      = 4'd0,
    MSG_RDX     = 4'd1,
    MSG_WB      = 4'd2,
    MSG_RCL_ACK = 4'd3,
    MSG_FWD_ACK = 4'd4,
    MSG_INV_ACK = 4'd5,
    MSG_RD_RPL  = 4'd8,
    MSG_RDX_RPL = 4'd9,
    MSG_RCL     = 4'd10,
    MSG_FWD     = 4'd11,
    MSG_INV     = 4'd12,
    MSG_NACK    = 4'd13
  } msg_t;

  typedef enum logic [1:0] {LN_I = 2'd0, LN_S = 2'd1, LN_M = 2'd2} line_st_t;

  typedef enum logic [1:0] {PH_IDLE, PH_NOTIFY, PH_WAIT, PH_REPLY} phase_t;

  typedef enum logic [1:0] {K_RECALL, K_FWD, K_INV} kind_t;

  // message sent to holders for a given transaction kind
  function automatic msg_t notify_type(input kind_t k);
    case (k)
      K_RECALL: return MSG_RCL;
      K_FWD:    return MSG_FWD;
      default:  return MSG_INV;
    endcase
  endfunction

  // acknowledgement expected back for a given transaction kind
  function automatic msg_t ack_type(input kind_t k);
    case (k)
      K_RECALL: return MSG_RCL_ACK;
      K_FWD:    return MSG_FWD_ACK;
      default:  return MSG_INV_ACK;
    endcase
  endfunction

  function automatic logic is_request(input msg_t t);
    return (t == MSG_RD) || (t == MSG_RDX) || (t == MSG_WB);
  endfunction

endpackage

// File: rtl/dir_table.sv
module dir_table import dir_pkg::*; #(
  parameter int N_CORES = 4,
  parameter int N_LINES = 8,
  localparam int CORE_W = (N_CORES > 1) ? $clog2(N_CORES) : 1,
  localparam int LINE_W = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LINE_W-1:0]  raddr,
  output line_st_t           rd_st,
  output logic [CORE_W-1:0]  rd_own,
  output logic [N_CORES-1:0] rd_shr,
  input  logic               we,
  input  logic [LINE_W-1:0]  waddr,
  input  line_st_t           wr_st,
  input  logic [CORE_W-1:0]  wr_own,
  input  logic [N_CORES-1:0] wr_shr
);

  line_st_t           st_q  [N_LINES];
  logic [CORE_W-1:0]  own_q [N_LINES];
  logic [N_CORES-1:0] shr_q [N_LINES];

  always_ff @(posedge clk) begin
    for (int i = 0; i < N_LINES; i++) begin
      if (!rst_n) begin
        st_q[i]  <= LN_I;
        own_q[i] <= '0;
        shr_q[i] <= '0;
      end else if (we && (waddr == LINE_W'(i))) begin
        st_q[i]  <= wr_st;
        own_q[i] <= wr_own;
        shr_q[i] <= wr_shr;
      end
    end
  end

  assign rd_st  = st_q[raddr];
  assign rd_own = own_q[raddr];
  assign rd_shr = shr_q[raddr];

  // a modified line carries no sharer bits, an uncached one carries none either
  for (genvar g = 0; g < N_LINES; g++) begin : g_line_chk
    assert_m_alone_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q[g] != LN_S) |-> (shr_q[g] == '0));
  end

endmodule

// File: rtl/dir_pick.sv
module dir_pick #(
  parameter int N_CORES = 4,
  localparam int CORE_W = (N_CORES > 1) ? $clog2(N_CORES) : 1
) (
  input  logic [N_CORES-1:0] mask,
  output logic [CORE_W-1:0]  idx,
  output logic               any
);

  always_comb begin
    idx = '0;
    any = 1'b0;
    for (int i = N_CORES - 1; i >= 0; i--) begin
      if (mask[i]) begin
        idx = CORE_W'(i);
        any = 1'b1;
      end
    end
  end

  // lowest set bit is chosen, giving ascending notify order
  always_comb begin
    if (any) begin
      assert_pick_lowest_R5: assert (mask[idx] && ((mask & ((N_CORES'(1) << idx) - N_CORES'(1))) == '0));
    end
  end

endmodule

// File: rtl/dir_home.sv
module dir_home import dir_pkg::*; #(
  parameter int N_CORES = 4,
  parameter int N_LINES = 8,
  localparam int CORE_W = (N_CORES > 1) ? $clog2(N_CORES) : 1,
  localparam int LINE_W = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fwd_mode,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [CORE_W-1:0] in_src,
  input  logic [3:0]        in_type,
  input  logic [LINE_W-1:0] in_addr,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [CORE_W-1:0] out_src,
  output logic [CORE_W-1:0] out_dst,
  output logic [3:0]        out_type,
  output logic [LINE_W-1:0] out_addr
);

  // ---------------- helpers ----------------
  function automatic logic [N_CORES-1:0] bit_of(input logic [CORE_W-1:0] id);
    logic [N_CORES-1:0] v;
    v = '0;
    v[id] = 1'b1;
    return v;
  endfunction

  function automatic logic [N_CORES-1:0] holders(input line_st_t st,
      input logic [CORE_W-1:0] own, input logic [N_CORES-1:0] shr);
    case (st)
      LN_M:    return bit_of(own);
      LN_S:    return shr;
      default: return '0;
    endcase
  endfunction

  // cores that must be told before the requester can be served
  function automatic logic [N_CORES-1:0] targets_for(input logic rdx,
      input line_st_t st, input logic [CORE_W-1:0] own,
      input logic [N_CORES-1:0] shr, input logic [CORE_W-1:0] src);
    if (rdx) return holders(st, own, shr) & ~bit_of(src);
    if (st == LN_M && own != src) return bit_of(own);
    return '0;
  endfunction

  // ---------------- state ----------------
  phase_t             phase_q;
  kind_t              kind_q;
  logic [CORE_W-1:0]  cur_src_q;
  logic               cur_rdx_q;
  logic [LINE_W-1:0]  cur_line_q;
  line_st_t           snap_st_q;
  logic [CORE_W-1:0]  snap_own_q;
  logic [N_CORES-1:0] snap_shr_q;
  logic [N_CORES-1:0] pend_q;   // holders still to be sent a message
  logic [N_CORES-1:0] wait_q;   // holders whose ack is still owed
  logic               nack_q;
  logic [CORE_W-1:0]  nack_dst_q;
  logic [LINE_W-1:0]  nack_line_q;

  // ---------------- directory storage ----------------
  line_st_t           rd_st;
  logic [CORE_W-1:0]  rd_own;
  logic [N_CORES-1:0] rd_shr;
  logic               tbl_we;
  logic [LINE_W-1:0]  tbl_waddr;
  line_st_t           tbl_st;
  logic [CORE_W-1:0]  tbl_own;
  logic [N_CORES-1:0] tbl_shr;

  dir_table #(.N_CORES(N_CORES), .N_LINES(N_LINES)) u_table (
    .clk(clk), .rst_n(rst_n), .raddr(in_addr),
    .rd_st(rd_st), .rd_own(rd_own), .rd_shr(rd_shr),
    .we(tbl_we), .waddr(tbl_waddr), .wr_st(tbl_st), .wr_own(tbl_own), .wr_shr(tbl_shr)
  );

  logic [CORE_W-1:0] pick_idx;
  logic              pick_any;

  dir_pick #(.N_CORES(N_CORES)) u_pick (.mask(pend_q), .idx(pick_idx), .any(pick_any));

  // ---------------- named events ----------------
  msg_t               in_msg;
  logic               ev_accept, ev_start, ev_wb, ev_ack_hit, ev_last_ack;
  logic               ev_nack_set, ev_out_fire, ev_complete;
  logic [N_CORES-1:0] start_tgt, pend_next;

  assign in_msg      = msg_t'(in_type);
  assign in_ready    = (phase_q == PH_IDLE) || (phase_q == PH_WAIT && !nack_q);
  assign ev_accept   = in_valid && in_ready;
  assign ev_start    = (phase_q == PH_IDLE) && ev_accept && (in_msg == MSG_RD || in_msg == MSG_RDX);
  assign ev_wb       = (phase_q == PH_IDLE) && ev_accept && (in_msg == MSG_WB)
                       && (rd_st == LN_M) && (rd_own == in_src);
  assign ev_ack_hit  = (phase_q == PH_WAIT) && ev_accept && (in_msg == ack_type(kind_q))
                       && (in_addr == cur_line_q) && wait_q[in_src];
  assign ev_last_ack = ev_ack_hit && ((wait_q & ~bit_of(in_src)) == '0);
  assign ev_nack_set = (phase_q == PH_WAIT) && ev_accept && is_request(in_msg);
  assign ev_out_fire = out_valid && out_ready;
  assign ev_complete = ((phase_q == PH_REPLY) && ev_out_fire) || (ev_last_ack && kind_q == K_FWD);
  assign start_tgt   = targets_for(in_msg == MSG_RDX, rd_st, rd_own, rd_shr, in_src);
  assign pend_next   = pend_q & ~bit_of(pick_idx);

  // ---------------- transaction engine ----------------
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q     <= PH_IDLE;
      kind_q      <= K_INV;
      cur_src_q   <= '0;
      cur_rdx_q   <= 1'b0;
      cur_line_q  <= '0;
      snap_st_q   <= LN_I;
      snap_own_q  <= '0;
      snap_shr_q  <= '0;
      pend_q      <= '0;
      wait_q      <= '0;
      nack_q      <= 1'b0;
      nack_dst_q  <= '0;
      nack_line_q <= '0;
    end else begin
      case (phase_q)
        PH_IDLE: begin
          if (ev_start) begin
            cur_src_q  <= in_src;
            cur_rdx_q  <= (in_msg == MSG_RDX);
            cur_line_q <= in_addr;
            snap_st_q  <= rd_st;
            snap_own_q <= rd_own;
            snap_shr_q <= rd_shr;
            pend_q     <= start_tgt;
            wait_q     <= start_tgt;
            kind_q     <= (in_msg == MSG_RDX) ? K_INV : (fwd_mode ? K_FWD : K_RECALL);
            phase_q    <= (start_tgt != '0) ? PH_NOTIFY : PH_REPLY;
          end
        end
        PH_NOTIFY: begin
          if (ev_out_fire) begin
            pend_q <= pend_next;
            if (pend_next == '0) phase_q <= PH_WAIT;
          end
        end
        PH_WAIT: begin
          if (ev_ack_hit) begin
            wait_q <= wait_q & ~bit_of(in_src);
            if (ev_last_ack) phase_q <= (kind_q == K_FWD) ? PH_IDLE : PH_REPLY;
          end
          if (ev_nack_set) begin
            nack_q      <= 1'b1;
            nack_dst_q  <= in_src;
            nack_line_q <= in_addr;
          end else if (nack_q && out_ready) begin
            nack_q <= 1'b0;
          end
        end
        default: begin
          if (ev_out_fire) phase_q <= PH_IDLE;
        end
      endcase
    end
  end

  // ---------------- directory update ----------------
  always_comb begin
    tbl_we    = ev_wb || ev_complete;
    tbl_waddr = ev_wb ? in_addr : cur_line_q;
    tbl_st    = LN_I;
    tbl_own   = '0;
    tbl_shr   = '0;
    if (ev_wb) begin
      tbl_st = LN_I;
    end else if (cur_rdx_q) begin
      tbl_st  = LN_M;
      tbl_own = cur_src_q;
    end else if (snap_st_q == LN_M && snap_own_q != cur_src_q) begin
      tbl_st  = LN_S;
      tbl_shr = bit_of(snap_own_q) | bit_of(cur_src_q);
    end else if (snap_st_q == LN_M) begin
      tbl_st  = LN_M;
      tbl_own = snap_own_q;
    end else begin
      tbl_st  = LN_S;
      tbl_shr = snap_shr_q | bit_of(cur_src_q);
    end
  end

  // ---------------- outgoing channel ----------------
  always_comb begin
    out_valid = 1'b0;
    out_src   = cur_src_q;
    out_dst   = cur_src_q;
    out_type  = MSG_RD_RPL;
    out_addr  = cur_line_q;
    case (phase_q)
      PH_NOTIFY: begin
        out_valid = pick_any;
        out_dst   = pick_idx;
        out_type  = notify_type(kind_q);
      end
      PH_WAIT: begin
        out_valid = nack_q;
        out_src   = nack_dst_q;
        out_dst   = nack_dst_q;
        out_type  = MSG_NACK;
        out_addr  = nack_line_q;
      end
      PH_REPLY: begin
        out_valid = 1'b1;
        out_type  = cur_rdx_q ? MSG_RDX_RPL : MSG_RD_RPL;
      end
      default: out_valid = 1'b0;
    endcase
  end

  // ---------------- checks ----------------
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable({out_src, out_dst, out_type, out_addr})));

  assert_nack_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_type == MSG_NACK) |-> (phase_q == PH_WAIT));

  assert_reply_after_acks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (out_type == MSG_RDX_RPL || out_type == MSG_RD_RPL)) |-> (wait_q == '0 && pend_q == '0));

  assert_holder_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (out_type == MSG_INV || out_type == MSG_RCL || out_type == MSG_FWD))
      |-> (holders(snap_st_q, snap_own_q, snap_shr_q)[out_dst] && out_dst != out_src));

  assert_fwd_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_last_ack && kind_q == K_FWD) |=> (phase_q == PH_IDLE && !out_valid));

endmodule

// File: tb/test_dir_home.sv
`timescale 1ns/1ps
module test_dir_home;

  localparam int NC = 4;
  localparam int NL = 8;
  localparam int CW = 2;
  localparam int LW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          fwd_mode = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [CW-1:0] in_src = '0;
  logic [3:0]    in_type = '0;
  logic [LW-1:0] in_addr = '0;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [CW-1:0] out_src, out_dst;
  logic [3:0]    out_type;
  logic [LW-1:0] out_addr;

  always #4 clk = ~clk;  // 125 MHz

  dir_home #(.N_CORES(NC), .N_LINES(NL)) i_dir_home (
    .clk(clk), .rst_n(rst_n), .fwd_mode(fwd_mode),
    .in_valid(in_valid), .in_ready(in_ready), .in_src(in_src), .in_type(in_type), .in_addr(in_addr),
    .out_valid(out_valid), .out_ready(out_ready), .out_src(out_src), .out_dst(out_dst),
    .out_type(out_type), .out_addr(out_addr)
  );

  // type codes
  localparam int T_RD = 0, T_RDX = 1, T_WB = 2, T_RACK = 3, T_FACK = 4, T_IACK = 5;
  localparam int T_RDR = 8, T_RDXR = 9, T_RCL = 10, T_FWD = 11, T_INV = 12, T_NACK = 13;

  typedef struct {
    int    src;
    int    dst;
    int    typ;
    int    addr;
    string req;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   fails = 0;
  bit   finished = 1'b0;

  // periodic backpressure on the outgoing channel (R10)
  int rdy_cnt = 0;
  always @(posedge clk) begin
    #1;
    rdy_cnt <= rdy_cnt + 1;
    out_ready <= ((rdy_cnt % 5) != 1) && ((rdy_cnt % 5) != 2);
  end

  // ---------------- monitor ----------------
  bit             stall_prev = 1'b0;
  logic [12:0]    prev_pay = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (stall_prev) begin
        checks++;
        if (!out_valid || {out_src, out_dst, out_type, out_addr} != prev_pay) begin
          fails++;
          $display("FAIL R10: held message changed, got v=%0b pay=%h expected v=1 pay=%h",
                   out_valid, {out_src, out_dst, out_type, out_addr}, prev_pay);
        end
      end
      if (out_valid && out_ready) begin
        checks++;
        if (q.size() == 0) begin
          fails++;
          $display("FAIL R7: unexpected message got src=%0d dst=%0d type=%0d addr=%0d expected none",
                   out_src, out_dst, out_type, out_addr);
        end else begin
          exp_t e;
          e = q.pop_front();
          if (int'(out_src) != e.src || int'(out_dst) != e.dst || int'(out_type) != e.typ ||
              int'(out_addr) != e.addr) begin
            fails++;
            $display("FAIL %s: got src=%0d dst=%0d type=%0d addr=%0d expected src=%0d dst=%0d type=%0d addr=%0d",
                     e.req, out_src, out_dst, out_type, out_addr, e.src, e.dst, e.typ, e.addr);
          end
        end
      end
      stall_prev = out_valid && !out_ready;
      prev_pay   = {out_src, out_dst, out_type, out_addr};
    end
  end

  // ---------------- driver ----------------
  task automatic expect_msg(input int s, input int d, input int t, input int a, input string r);
    exp_t e;
    e.src = s; e.dst = d; e.typ = t; e.addr = a; e.req = r;
    q.push_back(e);
  endtask

  task automatic send(input int s, input int t, input int a);
    @(negedge clk);
    in_valid = 1'b1;
    in_src   = CW'(s);
    in_type  = 4'(t);
    in_addr  = LW'(a);
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // wait until every expected message has appeared, then a quiet window
  task automatic drain(input string r);
    int n = 0;
    while (q.size() != 0 && n < 300) begin
      @(negedge clk);
      n++;
    end
    if (q.size() != 0) begin
      fails++;
      checks++;
      $display("FAIL %s: %0d expected message(s) never sent, got 0 expected %0d", r, q.size(), q.size());
      q.delete();
    end
    repeat (8) @(negedge clk);
  endtask

  task automatic check_idle(input string r);
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      fails++;
      $display("FAIL %s: idle check got out_valid=%0b in_ready=%0b expected 0 1", r, out_valid, in_ready);
    end
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    check_idle("R1");

    // R2 / R1: first read of an uncached line, then a second sharer
    expect_msg(1, 1, T_RDR, 2, "R2");
    send(1, T_RD, 2);
    drain("R2");
    expect_msg(2, 2, T_RDR, 2, "R2");
    send(2, T_RD, 2);
    drain("R2");

    // R5: line 2 shared by 1 and 2, exclusive from 3
    expect_msg(3, 1, T_INV, 2, "R5");
    expect_msg(3, 2, T_INV, 2, "R5");
    send(3, T_RDX, 2);
    drain("R5");
    send(1, T_IACK, 7);          // R11 wrong line
    send(1, T_IACK, 2);          // counted
    send(1, T_IACK, 2);          // R11 duplicate
    drain("R5 reply before all acks");
    // R8: requests while pending are refused
    expect_msg(0, 0, T_NACK, 2, "R8");
    send(0, T_RD, 2);
    drain("R8");
    expect_msg(0, 0, T_NACK, 4, "R8");
    send(0, T_RDX, 4);
    drain("R8");
    expect_msg(3, 3, T_RDXR, 2, "R5");
    send(2, T_IACK, 2);
    drain("R5");

    // R6 / R8: line 4 untouched by the refused request, so immediate reply
    expect_msg(0, 0, T_RDXR, 4, "R6");
    send(0, T_RDX, 4);
    drain("R6");

    // R3: recall path, line 2 owned by 3
    fwd_mode = 1'b0;
    expect_msg(1, 3, T_RCL, 2, "R3");
    send(1, T_RD, 2);
    drain("R3");
    send(3, T_IACK, 2);          // R11 wrong type
    drain("R3 reply before recall ack");
    expect_msg(1, 1, T_RDR, 2, "R3");
    send(3, T_RACK, 2);
    drain("R3");
    // line 2 now shared by 1 and 3
    expect_msg(2, 1, T_INV, 2, "R3");
    expect_msg(2, 3, T_INV, 2, "R3");
    send(2, T_RDX, 2);
    drain("R3");
    send(1, T_IACK, 2);
    expect_msg(2, 2, T_RDXR, 2, "R5");
    send(3, T_IACK, 2);
    drain("R5");

    // R4: forward path, line 2 owned by 2
    fwd_mode = 1'b1;
    expect_msg(0, 2, T_FWD, 2, "R4");
    send(0, T_RD, 2);
    drain("R4");
    send(2, T_RACK, 2);          // R11 wrong type for forward
    drain("R4");
    send(2, T_FACK, 2);
    drain("R4 home replied on forward");
    check_idle("R4");
    // line 2 shared by 0 and 2: requester 2 is not invalidated
    expect_msg(2, 0, T_INV, 2, "R5");
    send(2, T_RDX, 2);
    drain("R5");
    expect_msg(2, 2, T_RDXR, 2, "R5");
    send(0, T_IACK, 2);
    drain("R5");

    // R6: exclusive to a line modified elsewhere (line 4 owned by 0)
    expect_msg(1, 0, T_INV, 4, "R6");
    send(1, T_RDX, 4);
    drain("R6");
    expect_msg(1, 1, T_RDXR, 4, "R6");
    send(0, T_IACK, 4);
    drain("R6");

    // R9: writeback from a non-owner is ignored
    send(3, T_WB, 4);
    drain("R9");
    expect_msg(2, 1, T_INV, 4, "R9");
    send(2, T_RDX, 4);
    drain("R9");
    expect_msg(2, 2, T_RDXR, 4, "R9");
    send(1, T_IACK, 4);
    drain("R9");
    // owner writeback makes the line uncached: read served directly
    send(2, T_WB, 4);
    drain("R9");
    expect_msg(0, 0, T_RDR, 4, "R9");
    send(0, T_RD, 4);
    drain("R9");

    check_idle("R1");
    checks++;
    if (q.size() != 0) begin
      fails++;
      $display("FAIL R7: leftover expectations got %0d expected 0", q.size());
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule